// File: doc/BRIEF.md
# Sound Command Mailbox

This block passes single bytes between a 16-bit main processor and an 8-bit sound processor. The main processor writes a command byte on the upper byte lane of its data bus, which is the even-address byte, qualified by its upper data strobe. The block holds that byte and gives a one-clock notify pulse, which an external interrupt controller can turn into an interrupt for the sound processor. The sound processor reads the command over its own 8-bit port with an active-low read strobe.

The reverse direction is kept apart from the command direction. The sound processor writes a reply byte with an active-low write strobe, and the main processor reads it back on the same upper byte lane during a selected read cycle. A separate clear input empties the command byte and leaves the reply byte as it is. Address decoding on the main side, and any enabling of the interrupt, are done elsewhere.

All state is registered on the main clock. The read paths are combinational output enables with data, and they stand in for tri-state drivers.

Top module: `snd_mailbox`

## Requirements
- R1: After reset, the command byte and the reply byte both read as 0x00, and `cmd_notify` is low.
- R2: A main write is `host_sel`=1, `host_rw`=0 and `host_uds_n`=0. In the first clock cycle of such a write, the byte on `host_wdata` is loaded into the command byte at that clock edge.
- R3: `cmd_notify` goes high for exactly one clock after the edge that starts a main write. It stays low while the same write is held, and it pulses again only after the write condition has dropped and returned.
- R4: When `host_sel`=0, `host_uds_n`=1 or `host_rw`=1, no write takes place: the command byte is unchanged and `cmd_notify` stays low.
- R5: While `snd_rd_n`=0, `snd_oe`=1 and `snd_rdata` shows the command byte. Otherwise `snd_oe`=0 and `snd_rdata`=0x00.
- R6: At each clock edge where `snd_wr_n`=0, `snd_wdata` is loaded into the reply byte.
- R7: While `host_sel`=1, `host_rw`=1 and `host_uds_n`=0, `host_oe`=1 and `host_rdata` shows the reply byte. Otherwise `host_oe`=0 and `host_rdata`=0x00.
- R8: `cmd_clr`=1 at a clock edge sets the command byte to 0x00. It wins over a main write that starts at the same edge, which still produces its notify pulse.
- R9: `cmd_clr` has no effect on the reply byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Mailbox selected by the main address decode |
| host_rw | input | 1 | Main cycle direction, 1 = read |
| host_uds_n | input | 1 | Active-low upper (even) byte strobe |
| host_wdata | input | 8 | Main write data, upper byte lane |
| host_rdata | output | 8 | Reply byte toward the main processor |
| host_oe | output | 1 | Main-side read drive enable |
| snd_rd_n | input | 1 | Active-low sound-side read strobe |
| snd_wr_n | input | 1 | Active-low sound-side write strobe |
| snd_wdata | input | 8 | Sound-side reply data |
| snd_rdata | output | 8 | Command byte toward the sound processor |
| snd_oe | output | 1 | Sound-side read drive enable |
| cmd_clr | input | 1 | Clears the command byte |
| cmd_notify | output | 1 | One-clock pulse on each new command write |

## Verification
The bench holds a main write strobe for several cycles. A design that detects level instead of onset would then raise several notify pulses, or reload the command byte late.

The bench also starts a clear and a write at the same edge. A design with the priority reversed would keep the written byte.

It further tries writes with only one qualifier missing, to catch a decode that drops the strobe, the select or the direction term. It checks that clearing leaves the reply byte alone, so that a shared clear would show up as a lost reply.

// File: rtl/snd_mailbox_pkg.sv
package snd_mailbox_pkg;
    localparam int MBOX_W = 8;

    typedef logic [MBOX_W-1:0] mbox_byte_t;

    typedef struct packed {
        mbox_byte_t cmd;
        logic       wr_seen;
        logic       notify;
    } cmd_state_t;

    typedef struct packed {
        mbox_byte_t reply;
    } reply_state_t;
endpackage

// File: rtl/mbox_cmd_path.sv
module mbox_cmd_path
    import snd_mailbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_active,
    input  mbox_byte_t wdata,
    input  logic       clr,
    output mbox_byte_t cmd,
    output logic       notify
);
    cmd_state_t st_q, st_d;
    logic       onset;

    always_comb begin
        st_d         = st_q;
        onset        = wr_active && !st_q.wr_seen;
        st_d.wr_seen = wr_active;
        st_d.notify  = onset;
        if (clr)
            st_d.cmd = '0;
        else if (onset)
            st_d.cmd = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cmd    = st_q.cmd;
    assign notify = st_q.notify;
endmodule

// File: rtl/mbox_reply_path.sv
module mbox_reply_path
    import snd_mailbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_active,
    input  mbox_byte_t wdata,
    output mbox_byte_t reply
);
    reply_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wr_active)
            st_d.reply = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign reply = st_q.reply;
endmodule

// File: rtl/mbox_port_drive.sv
module mbox_port_drive
    import snd_mailbox_pkg::*;
(
    input  logic       en,
    input  mbox_byte_t data,
    output logic       oe,
    output mbox_byte_t rdata
);
    assign oe    = en;
    assign rdata = en ? data : '0;
endmodule

// File: rtl/snd_mailbox.sv
module snd_mailbox
    import snd_mailbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_rw,
    input  logic              host_uds_n,
    input  logic [MBOX_W-1:0] host_wdata,
    output logic [MBOX_W-1:0] host_rdata,
    output logic              host_oe,
    input  logic              snd_rd_n,
    input  logic              snd_wr_n,
    input  logic [MBOX_W-1:0] snd_wdata,
    output logic [MBOX_W-1:0] snd_rdata,
    output logic              snd_oe,
    input  logic              cmd_clr,
    output logic              cmd_notify
);
    logic       host_wr, host_rd;
    mbox_byte_t cmd_byte, reply_byte;

    assign host_wr = host_sel && !host_rw && !host_uds_n;
    assign host_rd = host_sel &&  host_rw && !host_uds_n;

    mbox_cmd_path u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_active (host_wr),
        .wdata     (host_wdata),
        .clr       (cmd_clr),
        .cmd       (cmd_byte),
        .notify    (cmd_notify)
    );

    mbox_reply_path u_reply (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_active (!snd_wr_n),
        .wdata     (snd_wdata),
        .reply     (reply_byte)
    );

    mbox_port_drive u_snd_drv (
        .en    (!snd_rd_n),
        .data  (cmd_byte),
        .oe    (snd_oe),
        .rdata (snd_rdata)
    );

    mbox_port_drive u_host_drv (
        .en    (host_rd),
        .data  (reply_byte),
        .oe    (host_oe),
        .rdata (host_rdata)
    );
endmodule

// File: rtl/snd_mailbox_chk.sv
module snd_mailbox_chk
    import snd_mailbox_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       host_sel,
    input logic       host_rw,
    input logic       host_uds_n,
    input mbox_byte_t host_wdata,
    input logic       snd_wr_n,
    input mbox_byte_t snd_wdata,
    input mbox_byte_t snd_rdata,
    input logic       snd_oe,
    input logic       cmd_clr,
    input logic       cmd_notify,
    input mbox_byte_t cmd_byte,
    input mbox_byte_t reply_byte
);
    logic wr_cond;
    assign wr_cond = host_sel && !host_rw && !host_uds_n;

    p_notify_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_notify |=> !cmd_notify);

    p_notify_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_notify |-> $past(wr_cond));

    p_cmd_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_notify && !$past(cmd_clr)) |-> cmd_byte == $past(host_wdata));

    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cond && !cmd_clr) |=> $stable(cmd_byte));

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_clr |=> cmd_byte == '0);

    p_reply_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !snd_wr_n |=> reply_byte == $past(snd_wdata));

    p_snd_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snd_oe |-> snd_rdata == cmd_byte);
endmodule

bind snd_mailbox snd_mailbox_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_rw    (host_rw),
    .host_uds_n (host_uds_n),
    .host_wdata (host_wdata),
    .snd_wr_n   (snd_wr_n),
    .snd_wdata  (snd_wdata),
    .snd_rdata  (snd_rdata),
    .snd_oe     (snd_oe),
    .cmd_clr    (cmd_clr),
    .cmd_notify (cmd_notify),
    .cmd_byte   (cmd_byte),
    .reply_byte (reply_byte)
);

// File: tb/snd_mailbox_test.sv
module snd_mailbox_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0, host_rw = 1'b1, host_uds_n = 1'b1;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_oe;
    logic       snd_rd_n = 1'b1, snd_wr_n = 1'b1;
    logic [7:0] snd_wdata = '0;
    logic [7:0] snd_rdata;
    logic       snd_oe;
    logic       cmd_clr = 1'b0;
    logic       cmd_notify;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [7:0] m_cmd = '0, m_reply = '0;
    logic       m_prev = 1'b0, m_notify = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    snd_mailbox uut (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_rw(host_rw), .host_uds_n(host_uds_n),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_oe(host_oe),
        .snd_rd_n(snd_rd_n), .snd_wr_n(snd_wr_n), .snd_wdata(snd_wdata),
        .snd_rdata(snd_rdata), .snd_oe(snd_oe),
        .cmd_clr(cmd_clr), .cmd_notify(cmd_notify)
    );

    function automatic logic host_wr_now();
        return host_sel && !host_rw && !host_uds_n;
    endfunction

    function automatic logic host_rd_now();
        return host_sel && host_rw && !host_uds_n;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic onset;
        @(posedge clk);
        if (rst_n) begin
            onset    = host_wr_now() && !m_prev;
            m_prev   = host_wr_now();
            m_notify = onset;
            if (cmd_clr)    m_cmd = '0;
            else if (onset) m_cmd = host_wdata;
            if (!snd_wr_n)  m_reply = snd_wdata;
        end
        #(CLK_P/4);
        chk("R3 notify", {31'd0, cmd_notify}, {31'd0, m_notify});
        chk("R5 snd_oe", {31'd0, snd_oe}, {31'd0, !snd_rd_n});
        chk("R5 snd_rdata", {24'd0, snd_rdata}, {24'd0, (!snd_rd_n ? m_cmd : 8'h00)});
        chk("R7 host_oe", {31'd0, host_oe}, {31'd0, host_rd_now()});
        chk("R7 host_rdata", {24'd0, host_rdata}, {24'd0, (host_rd_now() ? m_reply : 8'h00)});
    endtask

    task automatic idle();
        host_sel = 0; host_rw = 1; host_uds_n = 1;
        snd_rd_n = 1; snd_wr_n = 1; cmd_clr = 0;
    endtask

    task automatic host_write(input logic [7:0] d);
        host_sel = 1; host_rw = 0; host_uds_n = 0; host_wdata = d;
    endtask

    task automatic peek(output logic [7:0] c, output logic [7:0] r);
        idle();
        snd_rd_n = 0; host_sel = 1; host_rw = 1; host_uds_n = 0;
        #1;
        c = snd_rdata; r = host_rdata;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] c, r;
        int pulses;
        void'($urandom(32'd20240607));
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        peek(c, r);
        chk("R1 cmd", {24'd0, c}, 32'h00);
        chk("R1 reply", {24'd0, r}, 32'h00);
        chk("R1 notify", {31'd0, cmd_notify}, 32'h0);
        tick();

        // R2: command load
        idle(); tick();
        host_write(8'hA5); tick();
        idle(); tick();
        peek(c, r);
        chk("R2 cmd", {24'd0, c}, 32'hA5);
        tick();

        // R3: held strobe gives one pulse
        idle(); tick();
        pulses = 0;
        host_write(8'h33);
        for (int i = 0; i < 4; i++) begin
            tick();
            if (cmd_notify) pulses++;
        end
        chk("R3 pulses", pulses, 1);
        idle(); tick();

        // R4: partial qualifiers ignored
        host_write(8'hC3); host_sel = 0; tick();
        chk("R4 notify sel", {31'd0, cmd_notify}, 32'h0);
        host_write(8'hC3); host_uds_n = 1; tick();
        chk("R4 notify uds", {31'd0, cmd_notify}, 32'h0);
        host_write(8'hC3); host_rw = 1; tick();
        peek(c, r);
        chk("R4 cmd", {24'd0, c}, 32'h33);
        tick();

        // R6: reply load
        idle(); snd_wr_n = 0; snd_wdata = 8'h5A; tick();
        peek(c, r);
        chk("R6 reply", {24'd0, r}, 32'h5A);
        tick();

        // R8: clear beats simultaneous write; R9: reply survives
        idle(); tick();
        host_write(8'h77); cmd_clr = 1; tick();
        chk("R8 notify", {31'd0, cmd_notify}, 32'h1);
        peek(c, r);
        chk("R8 cmd", {24'd0, c}, 32'h00);
        chk("R9 reply", {24'd0, r}, 32'h5A);
        tick();

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            host_sel   = ($urandom % 4) != 0;
            host_rw    = $urandom % 2;
            host_uds_n = ($urandom % 4) == 0;
            host_wdata = $urandom;
            snd_rd_n   = $urandom % 2;
            snd_wr_n   = ($urandom % 3) != 0;
            snd_wdata  = $urandom;
            cmd_clr    = ($urandom % 8) == 0;
            tick();
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule